// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame should be kept, looking only at its 48-bit destination address. Address bytes are presented one per valid cycle after a start-of-frame strobe. While they stream in, the block does three things at once. It compares them with a programmed station address. It checks whether all of them are ones. It runs a bytewise CRC-32 over them, and the top six bits of that CRC pick one bit of a 64-bit multicast hash table.

After the sixth address byte, the block produces a single accept/reject decision and a hit class. A receive-mode field sets which classes are accepted: promiscuous, own unicast, multicast by hash, and broadcast. Two further bits of the same field are not used here. They are passed straight through so that later stages can decide whether to keep runt or errored frames.

Top module: `rx_addr_filter`

## Requirements
- R1: Out of reset, `dec_vld_o` and `accept_o` are 0 and `hit_o` is 0 (no hit).
- R2: The decision appears in the cycle after the clock edge that takes the sixth address byte. It stays unchanged until the next `sof_i`. Bytes beyond the sixth are ignored, and so are idle gaps between bytes.
- R3: When mode bit 1 (value 0x02) is set, a frame whose destination equals `station_addr_i` is accepted with hit code 1 (unicast). Address byte k occupies bits 8k+7:8k, and byte 0 is the first on the wire. A frame with any differing byte gets no unicast hit.
- R4: A destination of all ones is broadcast. With mode bit 3 (0x08) set it is accepted with hit code 2. Broadcast is tested before the hash, and a broadcast frame never takes the multicast path.
- R5: A non-broadcast frame is multicast when bit 0 of its first byte is 1. With mode bit 2 (0x04) set, it is accepted with hit code 3 if table bit `hash_tbl_i[idx]` is 1. Index bit 5 picks the upper (1) or lower (0) 32-bit word, and bits 4:0 pick the bit within that word.
- R6: The index `idx` is bits 31:26 of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7 and is seeded with all ones. Each byte is fed least significant bit first, one bit per step: shift left, and XOR in the polynomial when the old bit 31 XOR the data bit is 1. No final complement is applied.
- R7: With mode bit 0 (0x01) set, every frame is accepted. When no other class hits, the hit code is 4 (promiscuous).
- R8: With all 64 table bits set and mode bit 2 set, every multicast frame is accepted.
- R9: `pass_runt_o` follows mode bit 4 (0x10) and `pass_err_o` follows mode bit 5 (0x20) at all times.
- R10: A rejected frame shows `accept_o` = 0 with hit code 0. An accepted frame never shows hit code 0.
- R11: A `sof_i` that does not end an address clears `dec_vld_o`, `accept_o` and `hit_o` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of frame; a byte valid in the same cycle is address byte 0 |
| byte_vld_i | input | 1 | `byte_i` carries a frame byte |
| byte_i | input | 8 | Frame byte |
| station_addr_i | input | 48 | Own address, byte 0 in bits 7:0 |
| hash_tbl_i | input | 64 | Multicast hash table, bit n is index n |
| rx_mode_i | input | 6 | Receive-mode control bits |
| dec_vld_o | output | 1 | Decision valid |
| accept_o | output | 1 | Frame accepted |
| hit_o | output | 3 | 0 none, 1 unicast, 2 broadcast, 3 multicast, 4 promiscuous |
| pass_runt_o | output | 1 | Runt frames may pass downstream |
| pass_err_o | output | 1 | Errored frames may pass downstream |

## Verification
The assertions check on every cycle that a decision holds until the next start strobe, and that a start strobe clears it. They also check that the accept flag and the hit code always agree, that promiscuous mode forces acceptance, and that the CRC restarts from its all-ones seed. Whether the right class was chosen can only be shown by the bench scenarios. This covers the station compare, the broadcast-before-hash order, and the hash index that picks the correct table bit in either word. The bench checks these against a reference CRC and reference decision rules, using directed addresses and random frames.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  typedef enum logic [2:0] {
    HIT_NONE    = 3'd0,
    HIT_UCAST   = 3'd1,
    HIT_BCAST   = 3'd2,
    HIT_MCAST   = 3'd3,
    HIT_PROMISC = 3'd4
  } hit_e;

  localparam int MODE_W    = 6;
  localparam int M_ALLPHYS = 0;
  localparam int M_MYPHYS  = 1;
  localparam int M_MCAST   = 2;
  localparam int M_BCAST   = 3;
  localparam int M_RUNT    = 4;
  localparam int M_ERR     = 5;
endpackage

// File: rtl/dafilt_crc.sv
module dafilt_crc #(
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = 32'h04C11DB7,
  parameter int          BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_nxt_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_step;

  // Next-state: seed on clear, then fold in one byte LSB first
  always_comb begin
    crc_base = clr_i ? {CRC_W{1'b1}} : crc_q;
    crc_step = crc_base;
    for (int b = 0; b < BYTE_W; b++) begin
      if (crc_step[CRC_W-1] ^ data_i[b])
        crc_step = {crc_step[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
      else
        crc_step = {crc_step[CRC_W-2:0], 1'b0};
    end
    crc_nxt_o = en_i ? crc_step : crc_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              crc_q <= {CRC_W{1'b1}};
    else if (clr_i || en_i)  crc_q <= crc_nxt_o;
  end

  // R6: a strobe with no byte leaves the engine at its seed
  a_r6_seed_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !en_i |=> crc_q == {CRC_W{1'b1}});
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  localparam int ADDR_W    = ADDR_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] station_i,
  output logic              take_o,
  output logic              last_o,
  output logic              mine_o,
  output logic              bcast_o,
  output logic              mcast_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_nxt;
  logic              mine_q, bc_q, mc_q;
  logic [BYTE_W-1:0] stn_byte;
  logic              first;

  always_comb begin
    cnt_base = sof_i ? '0 : cnt_q;
    first    = (cnt_base == '0);
    take_o   = vld_i && (cnt_base < CNT_W'(ADDR_BYTES));
    last_o   = take_o && (cnt_base == CNT_W'(ADDR_BYTES - 1));
    stn_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_base == CNT_W'(i)) stn_byte = station_i[i*BYTE_W +: BYTE_W];
    mine_o  = (first ? 1'b1 : mine_q) && (byte_i == stn_byte);
    bcast_o = (first ? 1'b1 : bc_q) && (byte_i == {BYTE_W{1'b1}});
    mcast_o = first ? byte_i[0] : mc_q;
    cnt_nxt = take_o ? cnt_base + CNT_W'(1) : cnt_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(ADDR_BYTES);
      mine_q <= 1'b0;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
    end else if (sof_i || take_o) begin
      cnt_q <= cnt_nxt;
      if (take_o) begin
        mine_q <= mine_o;
        bc_q   <= bcast_o;
        mc_q   <= mcast_o;
      end
    end
  end

  // R2: the byte position never runs past the address length
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
  import dafilt_pkg::*;
#(
  parameter int HASH_BITS = 6,
  localparam int TBL_SZ   = 1 << HASH_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sof_i,
  input  logic                 last_i,
  input  logic                 mine_i,
  input  logic                 bcast_i,
  input  logic                 mcast_i,
  input  logic [HASH_BITS-1:0] idx_i,
  input  logic [TBL_SZ-1:0]    tbl_i,
  input  logic [3:0]           mode_i,
  output logic                 dec_vld_o,
  output logic                 accept_o,
  output hit_e                 hit_o
);
  hit_e cls;
  logic cls_acc;
  logic vld_nxt, acc_nxt;
  hit_e hit_nxt;

  always_comb begin
    cls     = HIT_NONE;
    cls_acc = 1'b0;
    if (bcast_i && mode_i[M_BCAST]) begin
      cls = HIT_BCAST;   cls_acc = 1'b1;
    end else if (!bcast_i && mcast_i && mode_i[M_MCAST] && tbl_i[idx_i]) begin
      cls = HIT_MCAST;   cls_acc = 1'b1;
    end else if (!mcast_i && mine_i && mode_i[M_MYPHYS]) begin
      cls = HIT_UCAST;   cls_acc = 1'b1;
    end else if (mode_i[M_ALLPHYS]) begin
      cls = HIT_PROMISC; cls_acc = 1'b1;
    end
  end

  always_comb begin
    vld_nxt = dec_vld_o;
    acc_nxt = accept_o;
    hit_nxt = hit_o;
    if (last_i) begin
      vld_nxt = 1'b1;
      acc_nxt = cls_acc;
      hit_nxt = cls;
    end else if (sof_i) begin
      vld_nxt = 1'b0;
      acc_nxt = 1'b0;
      hit_nxt = HIT_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_o <= 1'b0;
      accept_o  <= 1'b0;
      hit_o     <= HIT_NONE;
    end else if (last_i || sof_i) begin
      dec_vld_o <= vld_nxt;
      accept_o  <= acc_nxt;
      hit_o     <= hit_nxt;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && !sof_i |=> dec_vld_o && $stable(accept_o) && $stable(hit_o));
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i && !last_i |=> !dec_vld_o && !accept_o);
  a_r7_allphys: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_vld_o) && $past(mode_i[M_ALLPHYS]) |-> accept_o);
  a_r10_hit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> (accept_o == (hit_o != HIT_NONE)));
  a_r1_idle_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld_o |-> !accept_o && hit_o == HIT_NONE);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import dafilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int CRC_W      = 32,
  localparam int ADDR_W    = ADDR_BYTES * 8,
  localparam int TBL_SZ    = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [TBL_SZ-1:0] hash_tbl_i,
  input  logic [5:0]        rx_mode_i,
  output logic              dec_vld_o,
  output logic              accept_o,
  output logic [2:0]        hit_o,
  output logic              pass_runt_o,
  output logic              pass_err_o
);
  logic             take, last, mine, bcast, mcast;
  logic [CRC_W-1:0] crc_nxt;
  hit_e             hit;

  dafilt_match #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(8)) u_match (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .vld_i(byte_vld_i),
    .byte_i(byte_i), .station_i(station_addr_i), .take_o(take),
    .last_o(last), .mine_o(mine), .bcast_o(bcast), .mcast_o(mcast));

  dafilt_crc #(.CRC_W(CRC_W), .BYTE_W(8)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr_i(sof_i), .en_i(take),
    .data_i(byte_i), .crc_nxt_o(crc_nxt));

  dafilt_decide #(.HASH_BITS(HASH_BITS)) u_decide (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .last_i(last),
    .mine_i(mine), .bcast_i(bcast), .mcast_i(mcast),
    .idx_i(crc_nxt[CRC_W-1 -: HASH_BITS]), .tbl_i(hash_tbl_i),
    .mode_i(rx_mode_i[3:0]), .dec_vld_o(dec_vld_o),
    .accept_o(accept_o), .hit_o(hit));

  assign hit_o       = hit;
  assign pass_runt_o = rx_mode_i[M_RUNT];
  assign pass_err_o  = rx_mode_i[M_ERR];
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, vld = 1'b0;
  logic [7:0]  bt = '0;
  logic [47:0] sta = 48'h5544_3322_1100;
  logic [63:0] tbl = '0;
  logic [5:0]  mode = '0;
  logic        dvld, acc, prunt, perr;
  logic [2:0]  hit;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(bt),
    .station_addr_i(sta), .hash_tbl_i(tbl), .rx_mode_i(mode),
    .dec_vld_o(dvld), .accept_o(acc), .hit_o(hit),
    .pass_runt_o(prunt), .pass_err_o(perr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic        fb;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  // returns {accept, hit[2:0]}
  function automatic logic [3:0] ref_dec(input logic [47:0] a, input logic [5:0] m,
                                         input logic [47:0] s, input logic [63:0] t);
    logic bc = (a == 48'hFFFF_FFFF_FFFF);
    logic mc = a[0];
    logic [5:0] ix = ref_crc(a) >> 26;
    if (bc && m[3])                return 4'b1_010;
    if (!bc && mc && m[2] && t[ix]) return 4'b1_011;
    if (!mc && a == s && m[1])     return 4'b1_001;
    if (m[0])                      return 4'b1_100;
    return 4'b0_000;
  endfunction

  task automatic send(input logic [47:0] a, input int gap);
    @(negedge clk); sof = 1; vld = 1; bt = a[7:0];
    for (int i = 1; i < 6; i++) begin
      if (gap > 0) begin
        @(negedge clk); sof = 0; vld = 0;
        repeat (gap - 1) @(negedge clk);
      end
      @(negedge clk); sof = 0; vld = 1; bt = a[i*8 +: 8];
      if (i == 3) chk("R11 cleared mid-address", {31'd0, dvld}, 32'd0);
    end
    @(negedge clk); vld = 0; sof = 0;
  endtask

  task automatic frame(input string req, input logic [47:0] a, input int gap);
    logic [3:0] e;
    e = ref_dec(a, mode, sta, tbl);
    send(a, gap);
    chk({req, " valid"}, {31'd0, dvld}, 32'd1);
    chk({req, " accept"}, {31'd0, acc}, {31'd0, e[3]});
    chk({req, " hit"}, {29'd0, hit}, {29'd0, e[2:0]});
  endtask

  function automatic logic [47:0] rnd_addr();
    return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    logic [5:0]  ix;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dec_vld", {31'd0, dvld}, 32'd0);
    chk("R1 accept", {31'd0, acc}, 32'd0);
    chk("R1 hit", {29'd0, hit}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R3 unicast match and mismatch
    mode = 6'h02;
    frame("R3 own address", sta, 0);
    frame("R3 last byte differs", sta ^ 48'h0100_0000_0000, 0);
    frame("R3 first byte differs", sta ^ 48'h0000_0000_0004, 1);

    // R2 hold across idle cycles and trailing bytes
    repeat (3) @(negedge clk);
    vld = 1; bt = 8'h00; @(negedge clk); bt = 8'hFF; @(negedge clk); vld = 0;
    @(negedge clk);
    chk("R2 held valid", {31'd0, dvld}, 32'd1);
    chk("R2 held accept", {31'd0, acc}, 32'd0);
    frame("R2 gapped bytes", sta, 2);
    // R11 start strobe alone clears
    @(negedge clk); sof = 1; @(negedge clk); sof = 0;
    chk("R11 strobe clears valid", {31'd0, dvld}, 32'd0);
    chk("R11 strobe clears accept", {31'd0, acc}, 32'd0);

    // R4 broadcast
    mode = 6'h08;
    frame("R4 broadcast accepted", 48'hFFFF_FFFF_FFFF, 0);
    mode = 6'h04; tbl = '1;
    frame("R4 broadcast not via hash", 48'hFFFF_FFFF_FFFF, 0);

    // R5 R6 hash lookup, one bit set, each word
    mode = 6'h04;
    a = 48'h0000_5E00_0001;
    ix = ref_crc(a) >> 26;
    tbl = 64'd1 << ix;
    frame("R5 R6 exact hash bit", a, 0);
    tbl = ~(64'd1 << ix);
    frame("R5 R6 hash bit clear", a, 0);
    a = 48'h3300_0000_0033; ix = ref_crc(a) >> 26;
    tbl = 64'd1 << ix;
    frame("R5 second index", a, 0);
    for (int k = 0; k < 40; k++) begin
      a = rnd_addr() | 48'h1;
      ix = ref_crc(a) >> 26;
      tbl = (k % 2 == 0) ? (64'd1 << ix) : 64'd1 << (ix ^ 6'h20);
      frame("R5 word select", a, 0);
    end

    // R8 all ones table
    tbl = '1; mode = 6'h04;
    for (int k = 0; k < 8; k++) frame("R8 open table", rnd_addr() | 48'h1, 0);

    // R7 promiscuous
    mode = 6'h01; tbl = '0;
    frame("R7 random unicast", 48'h0A0B_0C0D_0E02, 0);
    frame("R7 multicast no hash", 48'h0A0B_0C0D_0E03, 0);
    mode = 6'h03;
    frame("R7 own keeps unicast class", sta, 0);

    // R9 pass-through bits
    mode = 6'h10; #1;
    chk("R9 runt", {30'd0, prunt, perr}, 32'd2);
    mode = 6'h20; #1;
    chk("R9 err", {30'd0, prunt, perr}, 32'd1);

    // R10 reject with nothing enabled
    mode = 6'h00;
    frame("R10 reject", sta, 0);

    // random mix
    for (int k = 0; k < 300; k++) begin
      int sel = $urandom_range(3);
      mode = 6'($urandom);
      tbl  = {$urandom, $urandom};
      case (sel)
        0: a = sta;
        1: a = 48'hFFFF_FFFF_FFFF;
        2: a = rnd_addr() | 48'h1;
        default: a = rnd_addr();
      endcase
      frame("R10 random mix", a, $urandom_range(1));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule